// File: doc/BRIEF.md
# Sorted-Vector Adaptive Censoring Unit

This unit estimates the background level of a block of non-negative samples while discarding impulsive outliers. A whole vector is captured in one cycle and put into ascending order by an odd-even transposition network. The unit then walks the ordered list from the smallest value upward. At each rank it decides whether the next sample still belongs to the clean background. The limit for that decision is the sum of the samples already accepted, multiplied by a scale factor that belongs to that rank. The scan stops at the first sample that reaches the limit. Everything below that point is clean, and everything from that point on is rejected.

The unit reports two results: the sum of the clean samples, which a detector can use as its interference estimate, and how many samples were clean. A one-cycle done pulse marks when both results are valid. The per-rank scale factors sit in a small table. They reset to a parameter value and can be rewritten through a write port. Working out their values from a target false-censoring rate is left to the user.

Top module: `sc_censor`

## Requirements
- R1: After a vector is accepted, the unit applies exactly N compare-exchange phases that alternate between even pairs (0,1),(2,3),… and odd pairs (1,2),(3,4),…, starting with even. The scan works only on the resulting ascending order, so the results do not depend on where a sample sat in `in_samples` (sample g occupies bits [16g+15:16g]).
- R2: For rank i from 1 to N-1, with s_i the sum of the i smallest samples and T_i the rank's 16-bit unsigned scale factor with 8 fractional bits, the scan stops at the first i where x(i+1)·256 ≥ s_i·T_i. Equality counts as a stop.
- R3: When the scan stops at rank i, `clean_cnt` is i and `est_sum` is s_i.
- R4: When no rank stops the scan, `clean_cnt` is N and `est_sum` is the sum of all N samples.
- R5: Writing `cfg_scale` with `cfg_we` high at `cfg_rank` = i-1 sets T_i and leaves the other ranks unchanged. After reset, every T_i is 0x0300 (3.0).
- R6: After reset, `est_sum`, `clean_cnt`, `done` and `busy` are 0. The two results keep their values until the next done pulse.
- R7: `done` is high for exactly one cycle, N+j clock edges after the edge that accepted the vector. Here j is the rank at which the scan stopped, or N-1 if it never stopped.
- R8: A vector is accepted on an edge where `in_valid` is high and `busy` is low. `busy` stays high until the done edge. A strobe that arrives while `busy` is high is ignored and does not change the result.
- R9: With N=16 samples of 0xFFFF and every scale factor at 0xFFFF, no overflow occurs: the result is a sum of 1048560 with a count of 16.
- R10: If the smallest sample is 0, the limit at rank 1 is 0, so the scan stops at once with a count of 1 and a sum of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that presents a new vector |
| in_samples | input | N*W | Flattened sample vector, sample g in bits [W*g+W-1:W*g] |
| cfg_we | input | 1 | Write enable for the scale table |
| cfg_rank | input | clog2(N-1) | Table address, i-1 for rank i |
| cfg_scale | input | TW | Scale factor, unsigned with FB fractional bits |
| busy | output | 1 | High while a vector is being sorted or scanned |
| done | output | 1 | One-cycle pulse when the results update |
| est_sum | output | W+clog2(N) | Sum of the clean samples |
| clean_cnt | output | clog2(N+1) | Number of clean samples |

## Verification
The bench targets these corner cases:
- An exact tie between a sample and its limit. A design that used a strict comparison would keep the tied sample and report one more clean sample.
- A zero smallest sample. This gives a zero limit at rank 1 and must stop the scan immediately.
- A vector that never stops the scan. A design that got this wrong would report a count of N-1 or lose the last sample from the sum.
- Reverse-ordered input. A sort that is one phase short would leave samples out of order and give a different sum.
- A zero scale factor written to one rank. An off-by-one in the table address would stop the scan at the neighbouring rank.
- Full-scale samples combined with the largest scale factors. A product or sum that is too narrow would wrap and stop the scan early.
- A strobe sent in the middle of a run. A design that accepted it would corrupt the sorted vector.
- The done latency, which is measured for every vector.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SORT = 2'd1,
    ST_SCAN = 2'd2
  } sc_state_e;
endpackage

// File: rtl/sc_cmpx.sv
module sc_cmpx #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic a_small;
  assign a_small = (a <= b);
  assign lo = a_small ? a : b;
  assign hi = a_small ? b : a;
endmodule

// File: rtl/sc_oet_sorter.sv
module sc_oet_sorter #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N-1:0][W-1:0] in_vec,
  input  logic                step,
  input  logic                odd,
  output logic [N-1:0][W-1:0] vec_q,
  output logic [N-1:0][W-1:0] vec_d
);
  localparam int NE = N / 2;
  localparam int NO = (N - 1) / 2;

  logic [W-1:0] ev_lo [NE];
  logic [W-1:0] ev_hi [NE];
  logic [W-1:0] od_lo [NO];
  logic [W-1:0] od_hi [NO];

  for (genvar g = 0; g < NE; g++) begin : g_even
    sc_cmpx #(.W(W)) u_cx (
      .a (vec_q[2*g]),
      .b (vec_q[2*g+1]),
      .lo(ev_lo[g]),
      .hi(ev_hi[g])
    );
  end

  for (genvar g = 0; g < NO; g++) begin : g_odd
    sc_cmpx #(.W(W)) u_cx (
      .a (vec_q[2*g+1]),
      .b (vec_q[2*g+2]),
      .lo(od_lo[g]),
      .hi(od_hi[g])
    );
  end

  always_comb begin
    vec_d = vec_q;
    if (load) begin
      vec_d = in_vec;
    end else if (step) begin
      if (!odd) begin
        for (int g = 0; g < NE; g++) begin
          vec_d[2*g]   = ev_lo[g];
          vec_d[2*g+1] = ev_hi[g];
        end
      end else begin
        for (int g = 0; g < NO; g++) begin
          vec_d[2*g+1] = od_lo[g];
          vec_d[2*g+2] = od_hi[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end
endmodule

// File: rtl/sc_rank_eval.sv
module sc_rank_eval #(
  parameter int W  = 16,
  parameter int SW = 20,
  parameter int TW = 16,
  parameter int FB = 8
) (
  input  logic [SW-1:0] acc,
  input  logic [W-1:0]  smp,
  input  logic [TW-1:0] scale,
  output logic          reject,
  output logic [SW-1:0] acc_next
);
  localparam int PW = SW + TW;

  // flag cell: sample reaches the scaled running sum
  function automatic logic outlier(input logic [SW-1:0] s, input logic [W-1:0] x,
                                   input logic [TW-1:0] t);
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    lhs = PW'(x) << FB;
    rhs = PW'(s) * PW'(t);
    return lhs >= rhs;
  endfunction

  // accumulate cell: add the sample only while it stays clean
  function automatic logic [SW-1:0] absorb(input logic [SW-1:0] s, input logic [W-1:0] x,
                                           input logic hit);
    return hit ? s : s + SW'(x);
  endfunction

  assign reject   = outlier(acc, smp, scale);
  assign acc_next = absorb(acc, smp, reject);
endmodule

// File: rtl/sc_censor.sv
module sc_censor #(
  parameter int          N         = 16,
  parameter int          W         = 16,
  parameter int          TW        = 16,
  parameter int          FB        = 8,
  parameter int unsigned DEF_SCALE = 768
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [N*W-1:0]               in_samples,
  input  logic                         cfg_we,
  input  logic [$clog2(N-1)-1:0]       cfg_rank,
  input  logic [TW-1:0]                cfg_scale,
  output logic                         busy,
  output logic                         done,
  output logic [W+$clog2(N)-1:0]       est_sum,
  output logic [$clog2(N+1)-1:0]       clean_cnt
);
  import sc_pkg::*;

  localparam int SW = W + $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);
  localparam int RW = $clog2(N - 1);
  localparam int NR = N - 1;

  sc_state_e           state;
  logic [IW-1:0]       phase;
  logic [IW-1:0]       rank;
  logic [SW-1:0]       acc;
  logic [TW-1:0]       scale_q [NR];
  logic [N-1:0][W-1:0] in_vec;
  logic [N-1:0][W-1:0] vec_q;
  logic [N-1:0][W-1:0] vec_d;

  // named internal events
  logic          accept;
  logic          sort_step;
  logic          last_phase;
  logic          scan_on;
  logic          final_rank;
  logic          reject;
  logic          stop_hit;
  logic [W-1:0]  cur_smp;
  logic [TW-1:0] cur_scale;
  logic [SW-1:0] acc_next;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign in_vec[g] = in_samples[g*W +: W];
  end

  assign accept     = in_valid && (state == ST_IDLE);
  assign sort_step  = (state == ST_SORT);
  assign last_phase = sort_step && (phase == IW'(N - 1));
  assign scan_on    = (state == ST_SCAN);
  assign final_rank = scan_on && (rank == IW'(N - 1));
  assign cur_smp    = vec_q[rank];
  assign cur_scale  = scale_q[RW'(rank - IW'(1))];
  assign stop_hit   = scan_on && reject;
  assign busy       = (state != ST_IDLE);

  sc_oet_sorter #(.N(N), .W(W)) u_sort (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .in_vec(in_vec),
    .step  (sort_step),
    .odd   (phase[0]),
    .vec_q (vec_q),
    .vec_d (vec_d)
  );

  sc_rank_eval #(.W(W), .SW(SW), .TW(TW), .FB(FB)) u_eval (
    .acc     (acc),
    .smp     (cur_smp),
    .scale   (cur_scale),
    .reject  (reject),
    .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) scale_q[r] <= TW'(DEF_SCALE);
    end else if (cfg_we && (int'(cfg_rank) < NR)) begin
      scale_q[cfg_rank] <= cfg_scale;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= '0;
      rank      <= '0;
      acc       <= '0;
      done      <= 1'b0;
      est_sum   <= '0;
      clean_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SORT;
            phase <= '0;
          end
        end
        ST_SORT: begin
          phase <= phase + IW'(1);
          if (last_phase) begin
            state <= ST_SCAN;
            rank  <= IW'(1);
            acc   <= SW'(vec_d[0]);
          end
        end
        ST_SCAN: begin
          if (reject) begin
            done      <= 1'b1;
            est_sum   <= acc;
            clean_cnt <= CW'(rank);
            state     <= ST_IDLE;
          end else if (final_rank) begin
            done      <= 1'b1;
            est_sum   <= acc_next;
            clean_cnt <= CW'(N);
            state     <= ST_IDLE;
          end else begin
            acc  <= acc_next;
            rank <= rank + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_censor_chk.sv
module sc_censor_chk #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int SW = 20,
  parameter int CW = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                busy,
  input logic                done,
  input logic [SW-1:0]       est_sum,
  input logic [CW-1:0]       clean_cnt,
  input logic                scan_on,
  input logic                stop_hit,
  input logic [N-1:0][W-1:0] vec
);
  localparam longint MAXS = longint'(N) * ((longint'(1) << W) - 1);

  logic sorted_ok;
  always_comb begin
    sorted_ok = 1'b1;
    for (int g = 0; g < N - 1; g++) if (vec[g] > vec[g+1]) sorted_ok = 1'b0;
  end

  a_r1_sorted_scan: assert property (@(posedge clk) disable iff (!rst_n)
    scan_on |-> sorted_ok);
  a_r2_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (done && !busy));
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clean_cnt != '0 && clean_cnt <= CW'(N)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(est_sum) && $stable(clean_cnt)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (longint'(est_sum) <= MAXS));
endmodule

bind sc_censor sc_censor_chk #(.N(N), .W(W), .SW(SW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .busy     (busy),
  .done     (done),
  .est_sum  (est_sum),
  .clean_cnt(clean_cnt),
  .scan_on  (scan_on),
  .stop_hit (stop_hit),
  .vec      (vec_q)
);

// File: tb/tb_sc_censor.sv
module tb_sc_censor;
  localparam int N = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [N-1:0][15:0]   in_samples = '0;
  logic                 cfg_we = 1'b0;
  logic [3:0]           cfg_rank = '0;
  logic [15:0]          cfg_scale = '0;
  logic                 busy, done;
  logic [19:0]          est_sum;
  logic [4:0]           clean_cnt;

  int checks = 0;
  int errors = 0;
  logic [15:0] bscale [N-1];

  always #10 clk = ~clk;

  sc_censor dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .cfg_we(cfg_we), .cfg_rank(cfg_rank), .cfg_scale(cfg_scale),
    .busy(busy), .done(done), .est_sum(est_sum), .clean_cnt(clean_cnt)
  );

  // stimulus table: base, step multiplier, spike lane mask, spike value
  localparam int unsigned TBL [8][4] = '{
    '{100,   7, 32'h0000,     0},
    '{50,    3, 32'h8001,  5000},
    '{20,   11, 32'h0010,     0},
    '{1,     1, 32'h0000,     0},
    '{300,   5, 32'h00F0, 60000},
    '{1000,  0, 32'hFFFF,     7},
    '{0,     0, 32'h0000,     0},
    '{65000, 9, 32'h0000,     0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent reference: insertion sort, then scan with wide integers
  function automatic void model(input logic [N-1:0][15:0] v, output longint sum,
                                output int cnt, output int last);
    longint a [N];
    for (int i = 0; i < N; i++) a[i] = longint'(v[i]);
    for (int i = 1; i < N; i++) begin
      longint key = a[i];
      int p = i - 1;
      while (p >= 0 && a[p] > key) begin a[p+1] = a[p]; p--; end
      a[p+1] = key;
    end
    sum = a[0]; cnt = N; last = N - 1;
    for (int r = 1; r < N; r++) begin
      if (a[r] * 256 >= sum * longint'(bscale[r-1])) begin
        cnt = r; last = r; return;
      end
      sum += a[r];
    end
  endfunction

  task automatic write_scale(input int rank, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rank = 4'(rank - 1); cfg_scale = val;
    @(negedge clk);
    cfg_we = 1'b0;
    bscale[rank-1] = val;
  endtask

  task automatic run_vec(input logic [N-1:0][15:0] v, output longint sum,
                         output int cnt, output int lat);
    @(negedge clk);
    in_samples = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 4 * N) begin @(negedge clk); lat++; end
    sum = longint'(est_sum); cnt = int'(clean_cnt);
  endtask

  task automatic run_and_check(input string tag, input logic [N-1:0][15:0] v);
    longint s, es; int c, ec, lat, el;
    model(v, es, ec, el);
    run_vec(v, s, c, lat);
    check({tag, " R3/R4 sum"}, s, es);
    check({tag, " R2 count"}, c, ec);
    check({tag, " R7 latency"}, lat, N + el);
  endtask

  function automatic logic [N-1:0][15:0] fill(input logic [15:0] val);
    logic [N-1:0][15:0] v;
    for (int g = 0; g < N; g++) v[g] = val;
    return v;
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0][15:0] v;
    longint s; int c, lat;
    for (int r = 0; r < N - 1; r++) bscale[r] = 16'h0300;
    repeat (3) @(negedge clk);
    // R6: reset values
    check("R6 reset est_sum", est_sum, 0);
    check("R6 reset clean_cnt", clean_cnt, 0);
    check("R6 reset busy", busy, 0);
    check("R6 reset done", done, 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R10 through the reference model
    for (int t = 0; t < 8; t++) begin
      for (int g = 0; g < N; g++) begin
        v[g] = 16'(TBL[t][0] + (g * TBL[t][1]) % 13);
        if (TBL[t][2][g]) v[g] = 16'(TBL[t][3]);
      end
      run_and_check($sformatf("tbl%0d", t), v);
    end

    // R4: flat vector never stops
    run_vec(fill(16'd10), s, c, lat);
    check("R4 flat sum", s, 160);
    check("R4 flat count", c, 16);
    check("R7 flat latency", lat, 31);

    // R2/R3: single spike rejected at rank 15
    v = fill(16'd10); v[3] = 16'd1000;
    run_vec(v, s, c, lat);
    check("R3 spike sum", s, 150);
    check("R3 spike count", c, 15);

    // R10: zero smallest sample
    v = fill(16'd5); v[9] = 16'd0;
    run_vec(v, s, c, lat);
    check("R10 zero sum", s, 0);
    check("R10 zero count", c, 1);
    check("R10 zero latency", lat, 17);

    // R1: reverse-ordered ramp 16..1 sorts to 1..16 and never stops
    for (int g = 0; g < N; g++) v[g] = 16'(N - g);
    run_vec(v, s, c, lat);
    check("R1 reverse sum", s, 136);
    check("R1 reverse count", c, 16);

    // R5: zero factor at rank 5 only
    write_scale(5, 16'h0000);
    run_vec(fill(16'd10), s, c, lat);
    check("R5 rank5 sum", s, 50);
    check("R5 rank5 count", c, 5);
    check("R7 rank5 latency", lat, 21);
    write_scale(5, 16'h0300);

    // R2: exact tie at rank 1 stops; a hair above does not
    write_scale(1, 16'h0100);
    run_vec(fill(16'd100), s, c, lat);
    check("R2 tie count", c, 1);
    check("R2 tie sum", s, 100);
    write_scale(1, 16'h0101);
    run_vec(fill(16'd100), s, c, lat);
    check("R2 above-tie count", c, 16);
    check("R2 above-tie sum", s, 1600);
    write_scale(1, 16'h0300);

    // R8: strobe while busy is ignored
    @(negedge clk);
    in_samples = fill(16'd10); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    in_samples = fill(16'd0); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 busy held", busy, 1);
    lat = 0;
    while (!done && lat < 4 * N) begin @(negedge clk); lat++; end
    check("R8 ignored sum", est_sum, 160);
    check("R8 ignored count", clean_cnt, 16);
    @(negedge clk);
    check("R7 done single", done, 0);
    check("R6 hold sum", est_sum, 160);
    check("R8 idle after", busy, 0);

    // R9: full-scale samples and factors
    for (int r = 1; r < N; r++) write_scale(r, 16'hFFFF);
    run_vec(fill(16'hFFFF), s, c, lat);
    check("R9 max sum", s, 1048560);
    check("R9 max count", c, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule